// File: doc/BRIEF.md
# DMA Channel Arbiter with Context Save

This block is the control core of a small multi-channel DMA engine. Every channel is started in one of two ways. A software trigger pulse is held as pending until the block finishes. A hardware request level is sampled each time a frame boundary is reached. Among the channels that are requesting, the core grants the one with the lowest index. An active channel moves elements one at a time through a simple request/acknowledge handshake. After each acknowledged element, its read and write addresses advance by a fixed element size.

Each channel has a slot in a context store. The slot holds four working values: remaining frames, remaining elements, next read address and next write address. The core writes a slot only when a higher-priority request takes over at a frame boundary from a channel that still has frames left. When that stalled channel is granted again, it resumes from the slot rather than from its configuration. If a channel runs without interruption, or finishes its last frame while another request waits, its slot is never written.

Four sticky status flags per channel report progress: frame done, half block reached, block done and last frame started. A per-channel strobe clears all four flags of that channel. A read port exposes any channel's context slot for inspection.

Top module: `dma_ctx_core`

## Requirements
- R1: After reset, elem_req is 0, all four flag vectors are 0, and every context slot reads frames 0, elements 0, source 0 and destination 0.
- R2: A software-mode channel begins at its configured source and destination. rd_addr and wr_addr advance by ESZ (default 4) after each element where elem_req and elem_ack are both 1.
- R3: When the last element of a frame is acknowledged, the remaining frame count drops by one and the element count reloads from configuration. The frame-done bit of that channel is set. If the frame was the final one, the block-done bit is also set and the channel is released (elem_req falls).
- R4: The last-frame bit of a channel is set when a frame is dispatched while that channel's remaining frame count is 1.
- R5: The half-block bit of a channel is set at the end of the frame after which the remaining frame count equals the configured frame count divided by two, rounded down.
- R6: Flags are sticky. Bit c of flag_clr clears all four flags of channel c and no other channel. A set event in the same cycle takes precedence over the clear.
- R7: Arbitration happens only at frame boundaries, and the lowest requesting index wins. A request from a higher-index channel never interrupts the active channel.
- R8: When a lower-index request wins at the boundary of a channel that still has frames left, that channel's slot receives its remaining frames, the reloaded element count and its next source and destination addresses.
- R9: A preempted channel, when granted again, continues from the addresses and counts held in its slot.
- R10: When a channel finishes its last frame, its slot is not written, even if a higher-priority request is pending.
- R11: A channel that runs without being preempted never writes its slot. This includes a run where it was the only enabled channel.
- R12: A hardware-mode channel (hw_mode bit 1) runs a frame only when hw_req is 1 at the boundary. While it waits, elem_req stays 0 and no context is saved. sw_trig has no effect on a hardware-mode channel.
- R13: While elem_req is 1 and elem_ack is 0, rd_addr and wr_addr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | NCH | Channel enable |
| hw_mode | input | NCH | 1: hardware-request mode, 0: software-trigger mode |
| sw_trig | input | NCH | Software trigger pulses |
| hw_req | input | NCH | Hardware request levels |
| cfg_src | input | NCH*AW | Initial source address per channel |
| cfg_dst | input | NCH*AW | Initial destination address per channel |
| cfg_frames | input | NCH*CW | Frames per block per channel (at least 1) |
| cfg_elems | input | NCH*CW | Elements per frame per channel (at least 1) |
| elem_ack | input | 1 | Current element has been moved |
| flag_clr | input | NCH | Per-channel clear strobe for all flags |
| ctx_sel | input | IW | Channel whose context slot is shown |
| elem_req | output | 1 | An element is requested |
| rd_addr | output | AW | Read address of current element |
| wr_addr | output | AW | Write address of current element |
| act_ch | output | IW | Channel owning the working registers |
| ftc_flag | output | NCH | Frame-done flags |
| hbc_flag | output | NCH | Half-block flags |
| btc_flag | output | NCH | Block-done flags |
| lfs_flag | output | NCH | Last-frame-started flags |
| ctx_frames | output | CW | Saved remaining frames of ctx_sel |
| ctx_elems | output | CW | Saved element count of ctx_sel |
| ctx_src | output | AW | Saved source address of ctx_sel |
| ctx_dst | output | AW | Saved destination address of ctx_sel |

## Verification
The bench targets the boundary between a non-final frame and a final frame while a higher-priority hardware request is waiting. A design that saves on every switch would overwrite the slot of a finished channel. A design that never saves would restart the stalled channel at its configured addresses instead of the advanced ones. The bench also checks that a channel running alone leaves its slot at zero. It checks that a higher-index trigger does not cut into an active block, and that a hardware channel whose request drops keeps its place without a save. Finally, it checks that the half-block and last-frame flags appear in exactly the right frame. An off-by-one in the remaining count would shift them by a frame.

// File: rtl/dma_ctx_pkg.sv
// Shared definitions for the DMA context-save core.
// Assumes: none beyond IEEE 1800-2017.
package dma_ctx_pkg;
    // Controller phase: boundary (arbitrate) or moving elements.
    typedef enum logic {
        ST_BOUND = 1'b0,
        ST_MOVE  = 1'b1
    } dma_phase_e;
endpackage

// File: rtl/dma_prio_arb.sv
// Fixed-priority picker: returns the lowest set index of req.
// Assumes: N >= 2; purely combinational.
module dma_prio_arb #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the highest index down so the lowest set bit wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dma_ctx_store.sv
// Per-channel context slots: one write port (save), two read ports
// (restore and inspection). Slots reset to zero.
// Assumes: at most one save per cycle.
module dma_ctx_store #(
    parameter int N  = 4,
    parameter int IW = 2,
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wsel,
    input  logic [CW-1:0] wfrm,
    input  logic [CW-1:0] welm,
    input  logic [AW-1:0] wsrc,
    input  logic [AW-1:0] wdst,
    input  logic [IW-1:0] asel,
    output logic [CW-1:0] afrm,
    output logic [CW-1:0] aelm,
    output logic [AW-1:0] asrc,
    output logic [AW-1:0] adst,
    input  logic [IW-1:0] bsel,
    output logic [CW-1:0] bfrm,
    output logic [CW-1:0] belm,
    output logic [AW-1:0] bsrc,
    output logic [AW-1:0] bdst
);
    logic [CW-1:0] frm_q [N];
    logic [CW-1:0] elm_q [N];
    logic [AW-1:0] src_q [N];
    logic [AW-1:0] dst_q [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Capture the saved context of channel g when it is stalled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frm_q[g] <= '0;
                elm_q[g] <= '0;
                src_q[g] <= '0;
                dst_q[g] <= '0;
            end else if (we && (wsel == IW'(g))) begin
                frm_q[g] <= wfrm;
                elm_q[g] <= welm;
                src_q[g] <= wsrc;
                dst_q[g] <= wdst;
            end
        end
    end

    // Restore and inspection reads.
    always_comb begin
        afrm = frm_q[asel];
        aelm = elm_q[asel];
        asrc = src_q[asel];
        adst = dst_q[asel];
        bfrm = frm_q[bsel];
        belm = elm_q[bsel];
        bsrc = src_q[bsel];
        bdst = dst_q[bsel];
    end
endmodule

// File: rtl/dma_flag_bank.sv
// Sticky per-channel status flags with per-channel clear strobe.
// Assumes: a set in the same cycle as a clear wins.
module dma_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ftc,
    input  logic [N-1:0] set_hbc,
    input  logic [N-1:0] set_btc,
    input  logic [N-1:0] set_lfs,
    input  logic [N-1:0] clr,
    output logic [N-1:0] ftc,
    output logic [N-1:0] hbc,
    output logic [N-1:0] btc,
    output logic [N-1:0] lfs
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        // Hold each flag until its channel's clear strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ftc[g] <= 1'b0;
                hbc[g] <= 1'b0;
                btc[g] <= 1'b0;
                lfs[g] <= 1'b0;
            end else begin
                ftc[g] <= set_ftc[g] | (ftc[g] & ~clr[g]);
                hbc[g] <= set_hbc[g] | (hbc[g] & ~clr[g]);
                btc[g] <= set_btc[g] | (btc[g] & ~clr[g]);
                lfs[g] <= set_lfs[g] | (lfs[g] & ~clr[g]);
            end
        end
    end
endmodule

// File: rtl/dma_ctx_core.sv
// DMA channel core: frame-boundary fixed-priority arbitration, one set
// of working registers, context save only for a preempted incomplete
// channel, restore on re-grant, sticky progress flags.
// Assumes: configured frame and element counts are at least 1 and
// configuration of a channel is stable while it is in use.
module dma_ctx_core
    import dma_ctx_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 8,
    parameter int ESZ = 4,
    parameter int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    chan_en,
    input  logic [NCH-1:0]    hw_mode,
    input  logic [NCH-1:0]    sw_trig,
    input  logic [NCH-1:0]    hw_req,
    input  logic [NCH*AW-1:0] cfg_src,
    input  logic [NCH*AW-1:0] cfg_dst,
    input  logic [NCH*CW-1:0] cfg_frames,
    input  logic [NCH*CW-1:0] cfg_elems,
    input  logic              elem_ack,
    input  logic [NCH-1:0]    flag_clr,
    input  logic [IW-1:0]     ctx_sel,
    output logic              elem_req,
    output logic [AW-1:0]     rd_addr,
    output logic [AW-1:0]     wr_addr,
    output logic [IW-1:0]     act_ch,
    output logic [NCH-1:0]    ftc_flag,
    output logic [NCH-1:0]    hbc_flag,
    output logic [NCH-1:0]    btc_flag,
    output logic [NCH-1:0]    lfs_flag,
    output logic [CW-1:0]     ctx_frames,
    output logic [CW-1:0]     ctx_elems,
    output logic [AW-1:0]     ctx_src,
    output logic [AW-1:0]     ctx_dst
);
    localparam logic [AW-1:0] STEP  = AW'(ESZ);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    dma_phase_e     phase;
    logic           act_vld;
    logic [IW-1:0]  act_idx;
    logic [CW-1:0]  wk_frm, wk_elm;
    logic [AW-1:0]  wk_src, wk_dst;
    logic [NCH-1:0] sw_pend, saved;

    logic [NCH-1:0] req;
    logic           any_req;
    logic [IW-1:0]  win_idx;
    logic           take_new, keep_cur, save_go;
    logic           elem_done, frm_end, blk_end;
    logic [CW-1:0]  ld_frm, ld_elm, rs_frm, rs_elm;
    logic [AW-1:0]  ld_src, ld_dst, rs_src, rs_dst;
    logic [CW-1:0]  act_elm_cfg, act_frm_cfg;
    logic [NCH-1:0] win_oh, act_oh;
    logic [NCH-1:0] s_ftc, s_hbc, s_btc, s_lfs;

    // Requests: hardware level or latched software trigger, gated by enable.
    assign req = chan_en & ((hw_mode & hw_req) | (~hw_mode & sw_pend));

    dma_prio_arb #(.N(NCH), .IW(IW)) u_arb (
        .req (req),
        .any (any_req),
        .idx (win_idx)
    );

    // Boundary decisions: switch to a new owner, or continue the current one.
    assign take_new  = (phase == ST_BOUND) && any_req && (!act_vld || (win_idx < act_idx));
    assign keep_cur  = (phase == ST_BOUND) && any_req && act_vld && (win_idx == act_idx);
    assign save_go   = take_new && act_vld;
    assign elem_done = (phase == ST_MOVE) && elem_ack;
    assign frm_end   = elem_done && (wk_elm == ONE_C);
    assign blk_end   = frm_end && (wk_frm == ONE_C);

    dma_ctx_store #(.N(NCH), .IW(IW), .AW(AW), .CW(CW)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (save_go),
        .wsel (act_idx),
        .wfrm (wk_frm),
        .welm (wk_elm),
        .wsrc (wk_src),
        .wdst (wk_dst),
        .asel (win_idx),
        .afrm (rs_frm),
        .aelm (rs_elm),
        .asrc (rs_src),
        .adst (rs_dst),
        .bsel (ctx_sel),
        .bfrm (ctx_frames),
        .belm (ctx_elems),
        .bsrc (ctx_src),
        .bdst (ctx_dst)
    );

    // Select load values for the winner and configuration of the owner.
    always_comb begin
        if (saved[win_idx]) begin
            ld_frm = rs_frm;
            ld_elm = rs_elm;
            ld_src = rs_src;
            ld_dst = rs_dst;
        end else begin
            ld_frm = cfg_frames[int'(win_idx)*CW +: CW];
            ld_elm = cfg_elems[int'(win_idx)*CW +: CW];
            ld_src = cfg_src[int'(win_idx)*AW +: AW];
            ld_dst = cfg_dst[int'(win_idx)*AW +: AW];
        end
        act_elm_cfg = cfg_elems[int'(act_idx)*CW +: CW];
        act_frm_cfg = cfg_frames[int'(act_idx)*CW +: CW];
        win_oh      = NCH'(1) << win_idx;
        act_oh      = NCH'(1) << act_idx;
    end

    // Flag set events for this cycle.
    always_comb begin
        s_ftc = frm_end ? act_oh : '0;
        s_btc = blk_end ? act_oh : '0;
        s_hbc = (frm_end && ((wk_frm - ONE_C) == (act_frm_cfg >> 1))) ? act_oh : '0;
        s_lfs = '0;
        if (take_new && (ld_frm == ONE_C)) s_lfs = win_oh;
        if (keep_cur && (wk_frm == ONE_C)) s_lfs = act_oh;
    end

    dma_flag_bank #(.N(NCH)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ftc(s_ftc),
        .set_hbc(s_hbc),
        .set_btc(s_btc),
        .set_lfs(s_lfs),
        .clr    (flag_clr),
        .ftc    (ftc_flag),
        .hbc    (hbc_flag),
        .btc    (btc_flag),
        .lfs    (lfs_flag)
    );

    // Pending software triggers and saved-context markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_pend <= '0;
            saved   <= '0;
        end else begin
            sw_pend <= (sw_pend & ~(blk_end ? act_oh : '0)) | (sw_trig & ~hw_mode & chan_en);
            saved   <= (saved & ~(take_new ? win_oh : '0)) | (save_go ? act_oh : '0);
        end
    end

    // Working registers and phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= ST_BOUND;
            act_vld <= 1'b0;
            act_idx <= '0;
            wk_frm  <= '0;
            wk_elm  <= '0;
            wk_src  <= '0;
            wk_dst  <= '0;
        end else if (phase == ST_BOUND) begin
            if (take_new) begin
                act_idx <= win_idx;
                act_vld <= 1'b1;
                wk_frm  <= ld_frm;
                wk_elm  <= ld_elm;
                wk_src  <= ld_src;
                wk_dst  <= ld_dst;
                phase   <= ST_MOVE;
            end else if (keep_cur) begin
                phase   <= ST_MOVE;
            end
        end else if (elem_done) begin
            wk_src <= wk_src + STEP;
            wk_dst <= wk_dst + STEP;
            if (frm_end) begin
                wk_elm <= act_elm_cfg;
                wk_frm <= wk_frm - ONE_C;
                phase  <= ST_BOUND;
                if (blk_end) act_vld <= 1'b0;
            end else begin
                wk_elm <= wk_elm - ONE_C;
            end
        end
    end

    assign elem_req = (phase == ST_MOVE);
    assign rd_addr  = wk_src;
    assign wr_addr  = wk_dst;
    assign act_ch   = act_idx;
endmodule

// File: rtl/dma_ctx_core_chk.sv
// Assertion checker for dma_ctx_core, attached by bind below.
// Assumes: observes internal save strobe, owner and working count.
module dma_ctx_core_chk #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 8,
    parameter int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           elem_req,
    input logic           elem_ack,
    input logic [AW-1:0]  rd_addr,
    input logic [AW-1:0]  wr_addr,
    input logic [IW-1:0]  act_ch,
    input logic [NCH-1:0] ftc_flag,
    input logic [NCH-1:0] btc_flag,
    input logic [NCH-1:0] flag_clr,
    input logic           save_go,
    input logic [CW-1:0]  wk_frm
);
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_req && !elem_ack) |=> ($stable(rd_addr) && $stable(wr_addr))); // R13

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(ftc_flag) & ~$past(flag_clr)) & ~ftc_flag) == '0)); // R6

    AST_BTC_WITH_FTC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((btc_flag & ~$past(btc_flag)) & ~ftc_flag) == '0)); // R3

    AST_SAVE_INCOMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        save_go |-> (wk_frm != '0)); // R10

    AST_SAVE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        save_go |-> !elem_req); // R7

    AST_SAVE_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
        save_go |=> (elem_req && (act_ch != $past(act_ch)))); // R8
endmodule

bind dma_ctx_core dma_ctx_core_chk #(.NCH(NCH), .AW(AW), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .elem_req(elem_req),
    .elem_ack(elem_ack),
    .rd_addr (rd_addr),
    .wr_addr (wr_addr),
    .act_ch  (act_ch),
    .ftc_flag(ftc_flag),
    .btc_flag(btc_flag),
    .flag_clr(flag_clr),
    .save_go (save_go),
    .wk_frm  (wk_frm)
);

// File: tb/sim_dma_ctx_core.sv
// Self-checking bench for dma_ctx_core: vector table of solo runs, then
// directed preemption, priority, hardware-mode and flag-clear cases.
module sim_dma_ctx_core;
    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int CW  = 8;
    localparam int ESZ = 4;
    localparam int IW  = 2;

    typedef struct packed {
        logic [1:0]  ch;
        logic [15:0] src;
        logic [15:0] dst;
        logic [7:0]  frm;
        logic [7:0]  elm;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 16'h1000, 16'h2000, 8'd2, 8'd3},
        '{2'd3, 16'h0100, 16'h0800, 8'd1, 8'd2},
        '{2'd0, 16'h4000, 16'h5000, 8'd4, 8'd1},
        '{2'd2, 16'h0010, 16'h0020, 8'd5, 8'd2},
        '{2'd1, 16'h3000, 16'h3100, 8'd3, 8'd1}
    };

    logic              clk, rst_n;
    logic [NCH-1:0]    chan_en, hw_mode, sw_trig, hw_req, flag_clr;
    logic [NCH*AW-1:0] cfg_src, cfg_dst;
    logic [NCH*CW-1:0] cfg_frames, cfg_elems;
    logic              elem_ack;
    logic [IW-1:0]     ctx_sel;
    logic              elem_req;
    logic [AW-1:0]     rd_addr, wr_addr, ctx_src, ctx_dst;
    logic [IW-1:0]     act_ch;
    logic [NCH-1:0]    ftc_flag, hbc_flag, btc_flag, lfs_flag;
    logic [CW-1:0]     ctx_frames, ctx_elems;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    dma_ctx_core #(.NCH(NCH), .AW(AW), .CW(CW), .ESZ(ESZ)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .hw_mode(hw_mode),
        .sw_trig(sw_trig), .hw_req(hw_req), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_frames(cfg_frames), .cfg_elems(cfg_elems), .elem_ack(elem_ack),
        .flag_clr(flag_clr), .ctx_sel(ctx_sel), .elem_req(elem_req),
        .rd_addr(rd_addr), .wr_addr(wr_addr), .act_ch(act_ch),
        .ftc_flag(ftc_flag), .hbc_flag(hbc_flag), .btc_flag(btc_flag),
        .lfs_flag(lfs_flag), .ctx_frames(ctx_frames), .ctx_elems(ctx_elems),
        .ctx_src(ctx_src), .ctx_dst(ctx_dst)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string tag, input longint actv, input longint expv);
        checks++;
        if (actv != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actv, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int c, input logic [15:0] s, input logic [15:0] d,
                           input logic [7:0] f, input logic [7:0] e);
        cfg_src[c*AW +: AW]    = s;
        cfg_dst[c*AW +: AW]    = d;
        cfg_frames[c*CW +: CW] = f;
        cfg_elems[c*CW +: CW]  = e;
    endtask

    task automatic pulse_sw(input int c);
        sw_trig[c] = 1'b1;
        tick(1);
        sw_trig[c] = 1'b0;
    endtask

    task automatic ack1();
        elem_ack = 1'b1;
        tick(1);
        elem_ack = 1'b0;
    endtask

    task automatic wait_req(input string tag);
        int n = 0;
        while (!elem_req && n < 300) begin
            tick(1);
            n++;
        end
        chk({tag, " elem_req timeout"}, elem_req, 1);
    endtask

    task automatic chk_ctx(input int c, input string tag, input int f, input int e,
                           input int s, input int d);
        ctx_sel = IW'(c);
        #1;
        chk({tag, " ctx frames"}, ctx_frames, f);
        chk({tag, " ctx elems"},  ctx_elems, e);
        chk({tag, " ctx src"},    ctx_src, s);
        chk({tag, " ctx dst"},    ctx_dst, d);
    endtask

    task automatic clear_all();
        flag_clr = '1;
        tick(1);
        flag_clr = '0;
    endtask

    // Watchdog: a hung run is counted as a failure and still summarised.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; chan_en = '0; hw_mode = '0; sw_trig = '0; hw_req = '0;
        flag_clr = '0; elem_ack = 1'b0; ctx_sel = '0;
        cfg_src = '0; cfg_dst = '0; cfg_frames = '0; cfg_elems = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        chk("R1 elem_req", elem_req, 0);
        chk("R1 flags", {ftc_flag, hbc_flag, btc_flag, lfs_flag}, 0);
        for (int c = 0; c < NCH; c++) chk_ctx(c, "R1", 0, 0, 0, 0);

        // Table of solo software-triggered runs.
        for (int v = 0; v < NV; v++) begin
            int c, fr, el;
            c  = int'(VEC[v].ch);
            fr = int'(VEC[v].frm);
            el = int'(VEC[v].elm);
            set_cfg(c, VEC[v].src, VEC[v].dst, VEC[v].frm, VEC[v].elm);
            chan_en = NCH'(1) << c;
            hw_mode = '0;
            clear_all();
            pulse_sw(c);
            for (int f = 0; f < fr; f++) begin
                wait_req("R2");
                chk("R4 last-frame flag", lfs_flag[c], (fr - f == 1) ? 1 : 0);
                for (int e = 0; e < el; e++) begin
                    chk("R2 rd_addr", rd_addr, int'(VEC[v].src) + (f * el + e) * ESZ);
                    chk("R2 wr_addr", wr_addr, int'(VEC[v].dst) + (f * el + e) * ESZ);
                    ack1();
                end
                chk("R3 frame-done flag", ftc_flag[c], 1);
                chk("R3 block-done flag", btc_flag[c], (f == fr - 1) ? 1 : 0);
                chk("R5 half-block flag", hbc_flag[c], ((fr - f - 1) <= fr / 2) ? 1 : 0);
            end
            tick(3);
            chk("R3 released", elem_req, 0);
            chk_ctx(c, "R11 solo", 0, 0, 0, 0);
        end

        // R6: per-channel clear; channel 1 holds flags from the last vector.
        flag_clr = 4'b0001;
        tick(1);
        flag_clr = '0;
        chk("R6 other channel kept", {ftc_flag[1], btc_flag[1], hbc_flag[1], lfs_flag[1]}, 4'hF);
        flag_clr = 4'b0010;
        tick(1);
        flag_clr = '0;
        chk("R6 cleared", {ftc_flag, hbc_flag, btc_flag, lfs_flag}, 0);

        // R13: no ack means addresses hold.
        set_cfg(1, 16'h0A00, 16'h0B00, 8'd1, 8'd2);
        chan_en = 4'b0010;
        pulse_sw(1);
        wait_req("R13");
        tick(4);
        chk("R13 still requesting", elem_req, 1);
        chk("R13 rd_addr held", rd_addr, 16'h0A00);
        ack1();
        chk("R13 step after ack", rd_addr, 16'h0A04);
        ack1();
        tick(2);

        // R8/R9: preemption of an incomplete channel and resume.
        set_cfg(2, 16'h0200, 16'h0600, 8'd3, 8'd2);
        set_cfg(0, 16'h7000, 16'h7800, 8'd1, 8'd1);
        chan_en = 4'b0101;
        hw_mode = 4'b0001;
        clear_all();
        pulse_sw(2);
        wait_req("R8");
        ack1();
        hw_req[0] = 1'b1;
        ack1();
        wait_req("R7");
        chk("R7 higher priority granted", act_ch, 0);
        chk("R7 rd_addr of winner", rd_addr, 16'h7000);
        chk_ctx(2, "R8 saved", 2, 2, 16'h0208, 16'h0608);
        ack1();
        hw_req[0] = 1'b0;
        wait_req("R9");
        chk("R9 resumed channel", act_ch, 2);
        chk("R9 resumed rd_addr", rd_addr, 16'h0208);
        chk("R9 resumed wr_addr", wr_addr, 16'h0608);
        for (int k = 0; k < 2; k++) ack1();
        wait_req("R9");
        chk("R4 last frame on resume", lfs_flag[2], 1);
        for (int k = 0; k < 2; k++) ack1();
        tick(2);
        chk("R3 block done after resume", btc_flag[2], 1);
        chk("R5 half block after resume", hbc_flag[2], 1);
        chk_ctx(2, "R10 slot unchanged after finish", 2, 2, 16'h0208, 16'h0608);

        // R10: last frame ends while higher priority waits, no save.
        set_cfg(3, 16'h0900, 16'h0980, 8'd1, 8'd2);
        chan_en = 4'b1001;
        pulse_sw(3);
        wait_req("R10");
        ack1();
        hw_req[0] = 1'b1;
        ack1();
        wait_req("R10");
        chk("R10 winner", act_ch, 0);
        chk_ctx(3, "R10 no save", 0, 0, 0, 0);
        ack1();
        hw_req[0] = 1'b0;
        tick(2);

        // R7: higher-index request does not interrupt the active block.
        set_cfg(1, 16'h0C00, 16'h0D00, 8'd2, 8'd1);
        set_cfg(3, 16'h0E00, 16'h0F00, 8'd1, 8'd1);
        chan_en = 4'b1010;
        hw_mode = '0;
        pulse_sw(1);
        wait_req("R7");
        pulse_sw(3);
        ack1();
        wait_req("R7");
        chk("R7 lower priority waits", act_ch, 1);
        chk("R7 continued rd_addr", rd_addr, 16'h0C04);
        chk_ctx(1, "R11 uninterrupted", 0, 0, 0, 0);
        ack1();
        wait_req("R7");
        chk("R7 then lower priority", act_ch, 3);
        ack1();
        tick(2);

        // R12: hardware mode ignores sw_trig and waits on hw_req.
        set_cfg(0, 16'h6000, 16'h6100, 8'd2, 8'd1);
        chan_en = 4'b0001;
        hw_mode = 4'b0001;
        pulse_sw(0);
        tick(5);
        chk("R12 sw_trig ignored", elem_req, 0);
        hw_req[0] = 1'b1;
        wait_req("R12");
        chk("R12 start rd_addr", rd_addr, 16'h6000);
        hw_req[0] = 1'b0;
        ack1();
        tick(5);
        chk("R12 waits without request", elem_req, 0);
        chk_ctx(0, "R12 no save while waiting", 0, 0, 0, 0);
        hw_req[0] = 1'b1;
        wait_req("R12");
        chk("R12 continues rd_addr", rd_addr, 16'h6004);
        ack1();
        hw_req[0] = 1'b0;
        tick(2);
        chk("R12 block done", btc_flag[0], 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule